// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page translations. Any translation may be stored in any slot. A lookup compares the incoming virtual page number against every slot at the same time. On a hit, the block returns the physical address within the same cycle. That address is the stored physical page number joined to the page offset, which passes through unchanged. On a miss, the block raises a request that carries the virtual page number, so that an external page-table walker can resolve it.

The walker returns its answer on a refill port. The block writes that translation into a slot when the next clock edge arrives. If the virtual page is already present, the existing slot is rewritten. Otherwise the slot is taken in round-robin order. A flush input empties the whole buffer in one clock edge. A debug flag reports the case where more than one slot matches a lookup. Protection checks and the page walk itself belong to the surrounding logic.

Top module: `xlat_buffer`

## Requirements
- R1: After reset no slot is valid, so every lookup misses until the first refill.
- R2: When `lookupValid` is high and a valid slot holds the incoming virtual page number (address bits [30:12]), `hit` is high in the same cycle. `physAddr` then equals that slot's 15-bit physical page number in bits [26:12] and the untouched 12-bit offset in bits [11:0].
- R3: When `lookupValid` is high and no valid slot matches, `missReq` is high, `missVpn` carries address bits [30:12], `hit` is low and `physAddr` is zero.
- R4: While `lookupValid` is low, `hit`, `missReq` and `multiHit` all stay low, whatever the address.
- R5: A refill becomes visible to lookups from the cycle after the clock edge that captures it. A lookup in the same cycle as the refill still sees the old contents.
- R6: A refill whose virtual page number is already held by a valid slot rewrites that slot in place and does not advance the replacement pointer.
- R7: A refill of a new virtual page goes into the slot under a round-robin pointer. The pointer starts at slot 0 after reset, moves up by one on each such install and wraps after slot ENTRIES-1, so the oldest install is the one evicted.
- R8: A flush empties every slot at one clock edge. A refill presented in the same cycle as a flush is discarded.
- R9: `multiHit` flags a lookup that matches more than one valid slot, and the lowest-numbered matching slot supplies the result. Because R6 stops duplicate entries from forming, the flag stays low under any sequence applied at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate every slot at the next edge |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVaddr | input | VPN_W+OFF_W | Virtual address to translate |
| hit | output | 1 | Lookup found a translation |
| physAddr | output | PPN_W+OFF_W | Translated address, zero when there is no hit |
| missReq | output | 1 | Lookup missed; request sent to the walker |
| missVpn | output | VPN_W | Virtual page number for the walker |
| multiHit | output | 1 | Debug: more than one slot matched |
| refillValid | input | 1 | Install a translation at the next edge |
| refillVpn | input | VPN_W | Virtual page number being installed |
| refillPpn | input | PPN_W | Physical page number being installed |

## Verification
The lookup outputs `hit`, `physAddr`, `missReq`, `missVpn` and `multiHit` are combinational, so they are due in the same cycle as the lookup inputs. The bench drives new inputs on the falling edge and samples these outputs 1 ns later. Refills and flushes register at the next rising edge, so their effect is due one cycle after they are presented. The bench holds them across that edge, drops them, and only then checks the outcome in the next cycle. This order lets it confirm both that a same-cycle lookup still sees the old contents and that the cycle after the edge sees the new ones.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int MAX_IDX_W = 4;

  typedef struct packed {
    logic                 clearAll;
    logic                 write;
    logic [MAX_IDX_W-1:0] writeIdx;
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xlatStrobe_t          strobe,
  input  logic [VPN_W-1:0]     lookupVpn,
  input  logic [VPN_W-1:0]     refillVpn,
  input  logic [PPN_W-1:0]     refillPpn,
  output logic                 matchAny,
  output logic                 matchMulti,
  output logic [PPN_W-1:0]     hitPpn,
  output logic                 refillDup,
  output logic [MAX_IDX_W-1:0] refillDupIdx
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PPN_W-1:0]   ppnQ [ENTRIES];
  logic [ENTRIES-1:0] lookupMatch;
  logic [ENTRIES-1:0] refillMatch;
  logic [IDX_W-1:0]   selIdx;

  // One storage slot and two comparators per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    assign lookupMatch[g] = validQ[g] && (vpnQ[g] == lookupVpn);
    assign refillMatch[g] = validQ[g] && (vpnQ[g] == refillVpn);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        vpnQ[g]   <= '0;
        ppnQ[g]   <= '0;
      end else if (strobe.clearAll) begin
        validQ[g] <= 1'b0;
      end else if (strobe.write && (strobe.writeIdx == MAX_IDX_W'(g))) begin
        validQ[g] <= 1'b1;
        vpnQ[g]   <= refillVpn;
        ppnQ[g]   <= refillPpn;
      end
    end
  end

  // Lowest-index match wins for the lookup result
  always_comb begin
    logic found;
    found  = 1'b0;
    selIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupMatch[i] && !found) begin
        found  = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  // Lowest-index match for the duplicate check on refill
  always_comb begin
    logic found;
    found        = 1'b0;
    refillDupIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (refillMatch[i] && !found) begin
        found        = 1'b1;
        refillDupIdx = MAX_IDX_W'(i);
      end
    end
  end

  assign matchAny   = |lookupMatch;
  assign matchMulti = (lookupMatch & (lookupMatch - 1'b1)) != '0;
  assign hitPpn     = ppnQ[selIdx];
  assign refillDup  = |refillMatch;
endmodule

// File: rtl/xlat_control.sv
module xlat_control
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flush,
  input  logic                 refillValid,
  input  logic                 refillDup,
  input  logic [MAX_IDX_W-1:0] refillDupIdx,
  output xlatStrobe_t          strobe
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtrQ;
  logic             installNew;

  assign installNew = refillValid && !flush && !refillDup;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rrPtrQ <= '0;
    else if (installNew) rrPtrQ <= (rrPtrQ == LAST) ? '0 : rrPtrQ + 1'b1;
  end

  always_comb begin
    strobe.clearAll = flush;
    strobe.write    = refillValid && !flush;
    strobe.writeIdx = refillDup ? refillDupIdx : MAX_IDX_W'(rrPtrQ);
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 19,
  parameter int PPN_W   = 15,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic                   lookupValid,
  input  logic [VPN_W+OFF_W-1:0] lookupVaddr,
  output logic                   hit,
  output logic [PPN_W+OFF_W-1:0] physAddr,
  output logic                   missReq,
  output logic [VPN_W-1:0]       missVpn,
  output logic                   multiHit,
  input  logic                   refillValid,
  input  logic [VPN_W-1:0]       refillVpn,
  input  logic [PPN_W-1:0]       refillPpn
);
  xlatStrobe_t          strobe;
  logic                 matchAny;
  logic                 matchMulti;
  logic [PPN_W-1:0]     hitPpn;
  logic                 refillDup;
  logic [MAX_IDX_W-1:0] refillDupIdx;
  logic [VPN_W-1:0]     lookupVpn;
  logic [OFF_W-1:0]     lookupOff;

  assign lookupVpn = lookupVaddr[VPN_W+OFF_W-1:OFF_W];
  assign lookupOff = lookupVaddr[OFF_W-1:0];

  xlat_control #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush), .refillValid(refillValid),
    .refillDup(refillDup), .refillDupIdx(refillDupIdx), .strobe(strobe)
  );

  xlat_datapath #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupVpn(lookupVpn),
    .refillVpn(refillVpn), .refillPpn(refillPpn), .matchAny(matchAny),
    .matchMulti(matchMulti), .hitPpn(hitPpn), .refillDup(refillDup),
    .refillDupIdx(refillDupIdx)
  );

  assign hit      = lookupValid && matchAny;
  assign missReq  = lookupValid && !matchAny;
  assign multiHit = lookupValid && matchMulti;
  assign missVpn  = lookupVpn;
  assign physAddr = hit ? {hitPpn, lookupOff} : '0;
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
  parameter int VPN_W = 19,
  parameter int PPN_W = 15,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   flush,
  input logic                   lookupValid,
  input logic [VPN_W+OFF_W-1:0] lookupVaddr,
  input logic                   hit,
  input logic [PPN_W+OFF_W-1:0] physAddr,
  input logic                   missReq,
  input logic                   multiHit,
  input logic                   refillValid,
  input logic [VPN_W-1:0]       refillVpn,
  input logic [PPN_W-1:0]       refillPpn
);
  logic [VPN_W-1:0] curVpn;
  assign curVpn = lookupVaddr[VPN_W+OFF_W-1:OFF_W];

  assert_hit_miss_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(hit && missReq));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> (!hit && !missReq && !multiHit));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hit);

  assert_refill_visible_R5: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !flush) |=>
      (!(lookupValid && curVpn == $past(refillVpn)) || hit));

  assert_refill_latest_ppn_R6: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !flush) |=>
      (!(lookupValid && curVpn == $past(refillVpn)) ||
       physAddr[PPN_W+OFF_W-1:OFF_W] == $past(refillPpn)));

  assert_no_duplicates_R9: assert property (@(posedge clk) disable iff (!rstN)
    !multiHit);

  assert_miss_quiet_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    missReq |-> (physAddr == '0));
endmodule

bind xlat_buffer xlat_checker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .flush(flush), .lookupValid(lookupValid),
  .lookupVaddr(lookupVaddr), .hit(hit), .physAddr(physAddr), .missReq(missReq),
  .multiHit(multiHit), .refillValid(refillValid), .refillVpn(refillVpn),
  .refillPpn(refillPpn)
);

// File: tb/tb_xlat_buffer.sv
module tb_xlat_buffer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        lookupValid = 1'b0;
  logic [30:0] lookupVaddr = '0;
  logic        hit;
  logic [26:0] physAddr;
  logic        missReq;
  logic [18:0] missVpn;
  logic        multiHit;
  logic        refillValid = 1'b0;
  logic [18:0] refillVpn = '0;
  logic [14:0] refillPpn = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  xlat_buffer dut (
    .clk(clk), .rstN(rstN), .flush(flush), .lookupValid(lookupValid),
    .lookupVaddr(lookupVaddr), .hit(hit), .physAddr(physAddr), .missReq(missReq),
    .missVpn(missVpn), .multiHit(multiHit), .refillValid(refillValid),
    .refillVpn(refillVpn), .refillPpn(refillPpn)
  );

  // op: 0 lookup, 1 refill, 2 flush | addr(31) | ppn(15) | expHit | expPa(27)
  localparam int NV = 19;
  localparam logic [75:0] VECS [NV] = '{
    {2'd0, 31'h0000247C, 15'h0000, 1'b0, 27'h0000000}, // R1 empty after reset
    {2'd1, 31'h00002000, 15'h7FFF, 1'b0, 27'h0000000}, // R7 -> slot 0
    {2'd1, 31'h7FFFD000, 15'h1234, 1'b0, 27'h0000000}, // R7 -> slot 1
    {2'd0, 31'h0000247C, 15'h0000, 1'b1, 27'h7FFF47C}, // R2
    {2'd0, 31'h00005FB0, 15'h0000, 1'b0, 27'h0000000}, // R3
    {2'd0, 31'h7FFFDABC, 15'h0000, 1'b1, 27'h1234ABC}, // R2
    {2'd1, 31'h00002000, 15'h0055, 1'b0, 27'h0000000}, // R6 rewrite slot 0
    {2'd0, 31'h00002000, 15'h0000, 1'b1, 27'h0055000}, // R6 new ppn
    {2'd1, 31'h00003000, 15'h0003, 1'b0, 27'h0000000}, // R7 -> slot 2
    {2'd1, 31'h00004000, 15'h0004, 1'b0, 27'h0000000}, // R7 -> slot 3
    {2'd1, 31'h00005000, 15'h0005, 1'b0, 27'h0000000}, // R7 wraps, evicts page 2
    {2'd0, 31'h00002FFF, 15'h0000, 1'b0, 27'h0000000}, // R7 evicted
    {2'd0, 31'h7FFFD000, 15'h0000, 1'b1, 27'h1234000}, // R6 pointer held
    {2'd0, 31'h00005FB0, 15'h0000, 1'b1, 27'h0005FB0}, // R7 new page
    {2'd0, 31'h00003123, 15'h0000, 1'b1, 27'h0003123}, // R2
    {2'd0, 31'h00004ABC, 15'h0000, 1'b1, 27'h0004ABC}, // R2
    {2'd2, 31'h00000000, 15'h0000, 1'b0, 27'h0000000}, // R8 flush
    {2'd0, 31'h00005FB0, 15'h0000, 1'b0, 27'h0000000}, // R8
    {2'd0, 31'h7FFFD000, 15'h0000, 1'b0, 27'h0000000}  // R8
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic lookupCheck(input string tag, input logic [30:0] va,
                             input logic expHit, input logic [26:0] expPa);
    lookupValid = 1'b1;
    lookupVaddr = va;
    #1;
    chk({tag, " hit"},      32'(hit),      32'(expHit));
    chk({tag, " physAddr"}, 32'(physAddr), 32'(expPa));
    chk({tag, " missReq"},  32'(missReq),  32'(!expHit));
    chk({"R9 ", tag, " multiHit"}, 32'(multiHit), 32'd0);
  endtask

  task automatic idleAll();
    lookupValid = 1'b0;
    refillValid = 1'b0;
    flush       = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state, nothing presented
    chk("R1 reset hit", 32'(hit), 32'd0);
    chk("R1 reset missReq", 32'(missReq), 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VECS[i];
      @(negedge clk);
      case (v[75:74])
        2'd0: lookupCheck(v[27] ? "R2" : "R3", v[73:43], v[27], v[26:0]);
        2'd1: begin
          refillValid = 1'b1;
          refillVpn   = v[73:55];
          refillPpn   = v[42:28];
        end
        default: flush = 1'b1;
      endcase
      @(posedge clk);
      #1 idleAll();
    end

    // R3 miss carries the page number for the walker
    @(negedge clk);
    lookupCheck("R3", 31'h00005FB0, 1'b0, 27'h0);
    chk("R3 missVpn", 32'(missVpn), 32'h5);
    @(posedge clk); #1 idleAll();

    // R5 refill and lookup together: old contents now, new ones next cycle
    @(negedge clk);
    refillValid = 1'b1; refillVpn = 19'h11; refillPpn = 15'h0AAA;
    lookupCheck("R5 same-cycle", 31'h00011040, 1'b0, 27'h0);
    @(posedge clk); #1 idleAll();
    @(negedge clk);
    lookupCheck("R5 next-cycle", 31'h00011040, 1'b1, {15'h0AAA, 12'h040});
    @(posedge clk); #1 idleAll();

    // R4 no lookup presented: outputs quiet even for a resident page
    @(negedge clk);
    lookupVaddr = 31'h00011040;
    #1;
    chk("R4 idle hit", 32'(hit), 32'd0);
    chk("R4 idle missReq", 32'(missReq), 32'd0);
    chk("R4 idle physAddr", 32'(physAddr), 32'd0);
    @(posedge clk); #1 idleAll();

    // R8 flush with a concurrent refill: the refill is dropped
    @(negedge clk);
    flush = 1'b1; refillValid = 1'b1; refillVpn = 19'h22; refillPpn = 15'h0022;
    @(posedge clk); #1 idleAll();
    @(negedge clk);
    lookupCheck("R8 dropped refill", 31'h00022000, 1'b0, 27'h0);
    @(posedge clk); #1 idleAll();
    @(negedge clk);
    lookupCheck("R8 flushed page", 31'h00011040, 1'b0, 27'h0);
    @(posedge clk); #1 idleAll();

    // R2 boundary pages: all-ones page number and offset
    @(negedge clk);
    refillValid = 1'b1; refillVpn = 19'h7FFFF; refillPpn = 15'h7FFF;
    @(posedge clk); #1 idleAll();
    @(negedge clk);
    lookupCheck("R2 max", 31'h7FFFFFFF, 1'b1, 27'h7FFFFFF);
    @(posedge clk); #1 idleAll();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule